// File: doc/BRIEF.md
# Ternary Fraction Switch Sequencer

The sequencer turns a target closure probability of the form a/3^m into the shortest chain of probabilistic switches that realizes it, where every switch is closed with probability 1/3 or 2/3. A start strobe loads the numerator and the exponent. The block first checks the target and cancels common factors of three. It then emits one switch per clock cycle, starting with the outermost switch and working inward. Each step tells whether the switch is the 1/3 or the 2/3 kind and whether it joins the remainder of the circuit in series or in parallel.

Each step is chosen by a greedy backward rule. The rule compares the numerator against one and two thirds of the current denominator and, in the middle band, looks at the numerator's parity. The denominator exponent then drops by one. When the remaining target is exactly 1/3 or 2/3, that switch is emitted as the final step. A target with a zero numerator, a numerator at or above its denominator, or an exponent outside 1..MAX_EXP produces an error completion with no steps.

The state machine has five states. IDLE waits for start. CHECK validates the loaded target. NORM removes one factor of three per cycle. EMIT outputs one switch per cycle. FIN raises done for one cycle.

The transitions are:
- IDLE to CHECK on start.
- CHECK to FIN when the target is invalid, otherwise CHECK to NORM.
- NORM stays in NORM while the exponent exceeds one and the numerator divides by three, otherwise NORM to EMIT.
- EMIT stays in EMIT until the exponent reaches one, then EMIT to FIN.
- FIN to IDLE.

Top module: `tern_switch_seq`

## Requirements
- R1: After reset, step_valid, step_last, seq_done and seq_error are all 0.
- R2: With the normalized target a/3^k and k > 1, a numerator a < 3^(k-1) emits a 1/3 switch in series (step_two_thirds=0, step_parallel=0), and the remaining target becomes a/3^(k-1).
- R3: A numerator with 3^(k-1) <= a < 2·3^(k-1) and k > 1 emits one of two steps. An odd a emits a 1/3 switch in parallel (step_two_thirds=0, step_parallel=1), leaving (a-3^(k-1))/2. An even a emits a 2/3 switch in series (step_two_thirds=1, step_parallel=0), leaving a/2.
- R4: A numerator a >= 2·3^(k-1) with k > 1 emits a 2/3 switch in parallel (step_two_thirds=1, step_parallel=1), leaving a-2·3^(k-1).
- R5: When the remaining target is 1/3 or 2/3, the block emits one final step. On that step step_last=1 together with step_valid, step_two_thirds=1 exactly when the target is 2/3, and step_parallel=0. step_last is never 1 on any other cycle.
- R6: Before stepping, factors of three common to a and 3^m are cancelled while m > 1. The number of steps then equals the reduced exponent. The steps, taken from outermost to innermost, compose to a circuit whose closure probability is exactly a/3^m.
- R7: A numerator of 0, a numerator >= 3^m, m = 0 or m > MAX_EXP ends with seq_done=1 and seq_error=1 in the same cycle, and no step is emitted.
- R8: seq_done is high for exactly one cycle. On a valid target it comes in the cycle right after the last step, and it never coincides with step_valid.
- R9: A start strobe while a sequence is in progress is ignored, and the sequence under way completes unchanged.
- R10: The target 40/81 yields exactly four steps: 2/3 series, 2/3 parallel, 1/3 series, and a final 2/3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load a new target (accepted only in IDLE) |
| num_in | input | NUM_W | Numerator a of the target |
| exp_in | input | EXP_W | Exponent m of the denominator 3^m |
| step_valid | output | 1 | A switch step is presented this cycle |
| step_two_thirds | output | 1 | 1: the switch is closed with 2/3, 0: with 1/3 |
| step_parallel | output | 1 | 1: the switch joins in parallel, 0: in series |
| step_last | output | 1 | This step is the innermost (final) switch |
| seq_done | output | 1 | One-cycle completion pulse |
| seq_error | output | 1 | With seq_done: the target was rejected |

## Verification
The bench builds the block with MAX_EXP set to 4, so NUM_W is 7 and EXP_W is 3. With that setting it sweeps every numerator from 0 to one past 3^m for every exponent from 0 to 4, plus exponents just beyond the limit. Every valid target, reducible ones included, is reconstructed by composing the emitted switches in exact integer arithmetic and compared with a/3^m. Every rejection path and each of the four placement rules is reached in the same sweep.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_NORM,
        S_EMIT,
        S_FIN
    } tfs_state_e;

    function automatic longint pow3(input int k);
        longint r;
        r = 1;
        for (int i = 0; i < k; i++) begin
            r = r * 3;
        end
        return r;
    endfunction

endpackage

// File: rtl/tfs_pow3_rom.sv
module tfs_pow3_rom #(
    parameter int MAX_EXP = 12,
    parameter int NUM_W   = 20,
    parameter int IDX_W   = 4
) (
    input  logic [IDX_W-1:0] idx,
    output logic [NUM_W-1:0] pow
);
    import tfs_pkg::*;

    logic [NUM_W-1:0] tbl [MAX_EXP+1];

    for (genvar g = 0; g <= MAX_EXP; g++) begin : g_entry
        assign tbl[g] = NUM_W'(pow3(g));
    end

    always_comb begin
        if (int'(idx) <= MAX_EXP) begin
            pow = tbl[idx];
        end else begin
            pow = '1;
        end
    end

endmodule

// File: rtl/tfs_reduce3.sv
module tfs_reduce3 #(
    parameter int NUM_W = 20
) (
    input  logic [NUM_W-1:0] num,
    output logic [NUM_W-1:0] quo,
    output logic             is_mult
);
    localparam logic [NUM_W-1:0] THREE = NUM_W'(3);

    always_comb begin
        quo     = num / THREE;
        is_mult = ((num % THREE) == '0);
    end

endmodule

// File: rtl/tfs_step_decide.sv
module tfs_step_decide #(
    parameter int NUM_W = 20
) (
    input  logic [NUM_W-1:0] num,
    input  logic [NUM_W-1:0] pow_lo,
    input  logic             final_step,
    output logic             two_thirds,
    output logic             parallel,
    output logic [NUM_W-1:0] next_num
);
    logic [NUM_W-1:0] twice_pow;
    logic [NUM_W-1:0] mid_diff;

    always_comb begin
        twice_pow = {pow_lo[NUM_W-2:0], 1'b0};
        mid_diff  = num - pow_lo;
        if (final_step) begin
            two_thirds = (num == NUM_W'(2));
            parallel   = 1'b0;
            next_num   = num;
        end else if (num < pow_lo) begin
            two_thirds = 1'b0;
            parallel   = 1'b0;
            next_num   = num;
        end else if (num < twice_pow) begin
            if (num[0]) begin
                two_thirds = 1'b0;
                parallel   = 1'b1;
                next_num   = mid_diff >> 1;
            end else begin
                two_thirds = 1'b1;
                parallel   = 1'b0;
                next_num   = num >> 1;
            end
        end else begin
            two_thirds = 1'b1;
            parallel   = 1'b1;
            next_num   = num - twice_pow;
        end
    end

endmodule

// File: rtl/tern_switch_seq.sv
module tern_switch_seq #(
    parameter  int MAX_EXP = 12,
    localparam int NUM_W   = $clog2(int'(tfs_pkg::pow3(MAX_EXP)) + 1),
    localparam int EXP_W   = $clog2(MAX_EXP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num_in,
    input  logic [EXP_W-1:0] exp_in,
    output logic             step_valid,
    output logic             step_two_thirds,
    output logic             step_parallel,
    output logic             step_last,
    output logic             seq_done,
    output logic             seq_error
);
    import tfs_pkg::*;

    tfs_state_e       state_q, state_d;
    logic [NUM_W-1:0] num_q;
    logic [EXP_W-1:0] exp_q;
    logic             err_q;

    logic [NUM_W-1:0] pow_hi, pow_lo, quo, next_num;
    logic             is_mult, two_sel, par_sel, final_step, bad_target, can_strip;

    tfs_pow3_rom #(.MAX_EXP(MAX_EXP), .NUM_W(NUM_W), .IDX_W(EXP_W)) u_pow_hi (
        .idx (exp_q),
        .pow (pow_hi)
    );

    tfs_pow3_rom #(.MAX_EXP(MAX_EXP), .NUM_W(NUM_W), .IDX_W(EXP_W)) u_pow_lo (
        .idx (exp_q - EXP_W'(1)),
        .pow (pow_lo)
    );

    tfs_reduce3 #(.NUM_W(NUM_W)) u_reduce (
        .num     (num_q),
        .quo     (quo),
        .is_mult (is_mult)
    );

    tfs_step_decide #(.NUM_W(NUM_W)) u_decide (
        .num        (num_q),
        .pow_lo     (pow_lo),
        .final_step (final_step),
        .two_thirds (two_sel),
        .parallel   (par_sel),
        .next_num   (next_num)
    );

    always_comb begin
        final_step = (exp_q == EXP_W'(1));
        bad_target = (exp_q == '0) || (int'(exp_q) > MAX_EXP) ||
                     (num_q == '0) || (num_q >= pow_hi);
        can_strip  = (exp_q > EXP_W'(1)) && is_mult;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_CHECK;
            S_CHECK: state_d = bad_target ? S_FIN : S_NORM;
            S_NORM:  state_d = can_strip ? S_NORM : S_EMIT;
            S_EMIT:  if (final_step) state_d = S_FIN;
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // target registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            num_q <= '0;
            exp_q <= '0;
            err_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        num_q <= num_in;
                        exp_q <= exp_in;
                        err_q <= 1'b0;
                    end
                end
                S_CHECK: err_q <= bad_target;
                S_NORM: begin
                    if (can_strip) begin
                        num_q <= quo;
                        exp_q <= exp_q - EXP_W'(1);
                    end
                end
                S_EMIT: begin
                    num_q <= next_num;
                    exp_q <= exp_q - EXP_W'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        step_valid      = (state_q == S_EMIT);
        step_two_thirds = step_valid && two_sel;
        step_parallel   = step_valid && par_sel;
        step_last       = step_valid && final_step;
        seq_done        = (state_q == S_FIN);
        seq_error       = seq_done && err_q;
    end

endmodule

// File: rtl/tfs_checker.sv
module tfs_checker (
    input logic clk,
    input logic rst_n,
    input logic step_valid,
    input logic step_two_thirds,
    input logic step_parallel,
    input logic step_last,
    input logic seq_done,
    input logic seq_error
);
    p_last_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_last |-> step_valid);

    p_final_in_series_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && step_last) |-> !step_parallel);

    p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && step_last) |=> (seq_done && !step_valid));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);

    p_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_valid, seq_done}));

    p_error_no_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_error |-> (seq_done && !$past(step_valid)));

    p_busy_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !step_last) |=> step_valid);

    p_flags_need_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_two_thirds || step_parallel) |-> step_valid);
endmodule

bind tern_switch_seq tfs_checker u_tfs_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .step_valid      (step_valid),
    .step_two_thirds (step_two_thirds),
    .step_parallel   (step_parallel),
    .step_last       (step_last),
    .seq_done        (seq_done),
    .seq_error       (seq_error)
);

// File: tb/test_tern_switch_seq.sv
module test_tern_switch_seq;
    localparam int MAXE = 4;
    localparam int NW   = $clog2(82);
    localparam int EW   = $clog2(MAXE + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NW-1:0] num_in = '0;
    logic [EW-1:0] exp_in = '0;
    logic          step_valid, step_two_thirds, step_parallel, step_last, seq_done, seq_error;

    int checks = 0;
    int errors = 0;

    int n_steps;
    bit st_two [32];
    bit st_par [32];
    bit st_last[32];
    bit got_err;
    int last_cyc, done_cyc;

    always #10 clk = ~clk;

    tern_switch_seq #(.MAX_EXP(MAXE)) i_tern_switch_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .start           (start),
        .num_in          (num_in),
        .exp_in          (exp_in),
        .step_valid      (step_valid),
        .step_two_thirds (step_two_thirds),
        .step_parallel   (step_parallel),
        .step_last       (step_last),
        .seq_done        (seq_done),
        .seq_error       (seq_error)
    );

    function automatic longint p3(input int k);
        longint r = 1;
        for (int i = 0; i < k; i++) r = r * 3;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp_v,
                         input int a, input int m);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s a=%0d m=%0d actual=%0d expected=%0d", req, a, m, act, exp_v);
        end
    endtask

    task automatic run(input int a, input int m, input int inj);
        int cyc;
        @(negedge clk);
        check(!seq_done && !step_valid, "R8 idle gap", seq_done, 0, a, m);
        num_in = NW'(a);
        exp_in = EW'(m);
        start  = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        n_steps  = 0;
        got_err  = 1'b0;
        last_cyc = -10;
        done_cyc = -1;
        cyc      = 0;
        forever begin
            if (inj >= 0 && cyc == inj + 1) start = 1'b0;
            if (step_valid) begin
                if (n_steps < 32) begin
                    st_two[n_steps]  = step_two_thirds;
                    st_par[n_steps]  = step_parallel;
                    st_last[n_steps] = step_last;
                end
                if (step_last) last_cyc = cyc;
                n_steps++;
            end
            if (seq_done) begin
                got_err  = seq_error;
                done_cyc = cyc;
                break;
            end
            if (inj >= 0 && cyc == inj) begin
                start  = 1'b1;
                num_in = NW'(1);
                exp_in = EW'(1);
            end
            cyc++;
            if (cyc > 80) begin
                check(1'b0, "watchdog run", cyc, 0, a, m);
                start = 1'b0;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic verify(input int a, input int m);
        int     an, mn, c, k;
        longint nn, pl;
        bit     invalid;
        invalid = (m == 0) || (m > MAXE) || (a == 0) || (longint'(a) >= p3(m));
        if (invalid) begin
            check(n_steps == 0, "R7 no steps", n_steps, 0, a, m);
            check(got_err, "R7 error flag", got_err, 1, a, m);
            return;
        end
        check(!got_err, "R7 no error", got_err, 0, a, m);
        an = a; mn = m;
        while (mn > 1 && (an % 3) == 0) begin
            an = an / 3; mn--;
        end
        check(n_steps == mn, "R6 step count", n_steps, mn, a, m);
        if (n_steps != mn || n_steps == 0) return;
        for (int i = 0; i < n_steps; i++) begin
            check(st_last[i] == (i == n_steps - 1), "R5 last placement", st_last[i], i == n_steps - 1, a, m);
        end
        check(!st_par[n_steps-1], "R5 final series", st_par[n_steps-1], 0, a, m);
        check(done_cyc == last_cyc + 1, "R8 done timing", done_cyc, last_cyc + 1, a, m);
        // compose innermost to outermost
        nn = st_two[n_steps-1] ? 2 : 1;
        k  = 1;
        for (int i = n_steps - 2; i >= 0; i--) begin
            c = st_two[i] ? 2 : 1;
            if (st_par[i]) nn = c * p3(k) + (3 - c) * nn;
            else           nn = c * nn;
            k++;
        end
        check(nn * p3(m) == longint'(a) * p3(k), "R6 composed probability", nn, an, a, m);
        // first step class
        if (mn == 1) begin
            check(st_two[0] == (an == 2), "R5 final value", st_two[0], an == 2, a, m);
        end else begin
            pl = p3(mn - 1);
            if (an < pl)
                check(!st_two[0] && !st_par[0], "R2 low band", {st_two[0], st_par[0]}, 0, a, m);
            else if (an < 2 * pl && (an % 2) == 1)
                check(!st_two[0] && st_par[0], "R3 middle odd", {st_two[0], st_par[0]}, 1, a, m);
            else if (an < 2 * pl)
                check(st_two[0] && !st_par[0], "R3 middle even", {st_two[0], st_par[0]}, 2, a, m);
            else
                check(st_two[0] && st_par[0], "R4 high band", {st_two[0], st_par[0]}, 3, a, m);
        end
    endtask

    initial begin
        #(200000 * 20);
        check(1'b0, "watchdog global", 0, 1, 0, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!step_valid && !step_last && !seq_done && !seq_error, "R1 reset outputs",
              {step_valid, step_last, seq_done, seq_error}, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!step_valid && !seq_done, "R1 idle after reset", {step_valid, seq_done}, 0, 0, 0);

        // R10 worked example
        run(40, 4, -1);
        verify(40, 4);
        check(n_steps == 4 && st_two[0] && !st_par[0] && st_two[1] && st_par[1] &&
              !st_two[2] && !st_par[2] && st_two[3] && st_last[3], "R10 40/81 sequence",
              {st_two[0], st_par[0], st_two[1], st_par[1], st_two[2], st_par[2], st_two[3]},
              7'b1011001, 40, 4);

        // R9 start while busy
        run(40, 4, 2);
        verify(40, 4);
        check(n_steps == 4, "R9 start ignored", n_steps, 4, 40, 4);
        run(71, 4, 1);
        verify(71, 4);

        // exhaustive sweep
        for (int m = 0; m <= MAXE + 1; m++) begin
            int top;
            top = (m <= MAXE) ? int'(p3(m)) + 1 : 5;
            for (int a = 0; a <= top; a++) begin
                run(a, m, -1);
                verify(a, m);
            end
        end
        run(5, 7, -1);
        verify(5, 7);

        @(negedge clk);
        check(!seq_done, "R8 done single", seq_done, 0, 0, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule